// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is a hardware refill engine for a translation lookaside buffer. When the lookup logic misses on a 32-bit virtual address, it hands the address and a read/write flag to the walker. The walker reads a first-level directory word and then a pair of second-level page table entries from memory, turns the two software entries into the even and odd EntryLo values and writes them, with the matching EntryHi value, into the slot named by the random replacement index. It then reports a single result: a match with the physical address, an invalid page, a dirty fault on a write, or a no-match that tells the core to take the normal software refill exception.

The walk runs in kernel context. While it runs, the walker presents the fault-address, page-table-context and entry-high views that a software handler would see. When the result is issued it puts back the values it captured when it accepted the miss, so software never sees that the walk happened. The directory base is a plain register input holding a kernel unmapped-segment address. The miss request and the memory read request are valid/ready streams: a source holds its payload steady until ready is seen high on a clock edge. The memory response has no ready and is always taken. Only one walk is in flight at a time.

Top module: `ptw_refill`

## Requirements
- R1: `miss_ready` is high only while the walker is idle. A miss is taken on a clock edge where `miss_valid` and `miss_ready` are both high. No new miss is taken until the result pulse for the current one has been issued, and `miss_ready` is low in the result cycle.
- R2: The first memory read of a walk is at (`dir_base` - 0x80000000) + 4 * VA[31:22].
- R3: From acceptance until the TLB write, `vis_badva` shows the miss address. `vis_context` shows the captured context with bits 22:0 replaced by (VA >> 9) & 0x007FFFF0. `vis_entryhi` shows (captured entry-high & 0xFF) | (VA & ~0x1FFF).
- R4: The second and third reads are at P + ((walk context >> 1) & 0xFF8) and that address + 4, where P is the directory word minus 0x80000000.
- R5: After the third read, `tlb_we` pulses for exactly one cycle. In that cycle `tlb_lo0` = even word >> 6, `tlb_lo1` = odd word >> 6, `tlb_entryhi` = the R3 entry-high value and `tlb_idx` = the `rand_idx` input. The result pulse follows in the next cycle.
- R6: VA bit 12 selects the entry: 1 selects the odd entry (EntryLo1) and 0 selects the even entry (EntryLo0).
- R7: `res_code` is 1 (invalid) when bit 1 of the selected EntryLo is 0. It is 2 (dirty fault) when that bit is 1, `miss_write` was 1 and bit 2 is 0. Otherwise it is 0 (match).
- R8: On a match `res_paddr` = ((EntryLo >> 6) << 12) | VA[11:0] for the selected EntryLo. For every other result it is 0.
- R9: A zero `dir_base` at acceptance gives `res_code` 3 (no match) in the next cycle, with no memory read and no TLB write.
- R10: In the result cycle the three `vis_*` outputs equal the `sw_*` values captured at acceptance, even if the inputs have since changed. While idle they follow the `sw_*` inputs.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_req_addr` stays unchanged.
- R12: `res_valid` is a single-cycle pulse, one per accepted miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle and able to take a miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_write | input | 1 | 1 for a store access |
| dir_base | input | 32 | Directory base, kernel unmapped-segment address, 0 when unset |
| sw_badva | input | 32 | Architectural fault-address register value |
| sw_context | input | 32 | Architectural context register value |
| sw_entryhi | input | 32 | Architectural entry-high register value |
| vis_badva | output | 32 | Fault-address view seen by the core |
| vis_context | output | 32 | Context view seen by the core |
| vis_entryhi | output | 32 | Entry-high view seen by the core |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical word address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| rand_idx | input | IDX_W | Random replacement slot |
| tlb_we | output | 1 | TLB write strobe |
| tlb_idx | output | IDX_W | Slot written |
| tlb_entryhi | output | 32 | EntryHi written |
| tlb_lo0 | output | 32 | Even EntryLo written |
| tlb_lo1 | output | 32 | Odd EntryLo written |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 0 match, 1 invalid, 2 dirty fault, 3 no match |
| res_paddr | output | 32 | Physical address on a match |

## Verification
The two functions that can meet in one cycle are the result pulse of one walk and a new miss request offered on the same edge. The bench provokes this by holding `miss_valid` high with the next address while a walk is still running. It judges the overlap from the order of memory read addresses and from `miss_ready` being low when the result pulse appears. The same back-to-back walks change the `sw_*` inputs in mid-walk, which checks that the result cycle restores the captured values and not the live ones. Memory stalls and delayed responses change the cycle in which each read completes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef logic [31:0] word_t;

  typedef enum logic [1:0] {
    RES_MATCH   = 2'd0,
    RES_INVALID = 2'd1,
    RES_DIRTY   = 2'd2,
    RES_NOMATCH = 2'd3
  } res_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    PH_DIR,
    PH_EVEN,
    PH_ODD
  } walk_phase_e;

endpackage

// File: rtl/ptw_addr_calc.sv
// Forms the kernel-context register views and the physical read address
// for each of the three reads of a walk.
module ptw_addr_calc
  import ptw_pkg::*;
#(
  parameter word_t KSEG_BASE  = 32'h8000_0000,
  parameter int    ASID_W     = 8,
  parameter int    PAGE_SHIFT = 12,
  parameter int    DIR_SHIFT  = 22
) (
  input  walk_phase_e                phase,
  input  logic [31:PAGE_SHIFT+1]     va_pair,
  input  word_t                      dir_ptr,
  input  word_t                      pt_ptr,
  input  word_t                      saved_ctx,
  input  word_t                      saved_ehi,
  output word_t                      walk_ctx,
  output word_t                      walk_ehi,
  output word_t                      rd_addr
);
  localparam int    PAIR_SHIFT = PAGE_SHIFT + 1;
  localparam word_t CTX_FIELD  = 32'h007F_FFFF;
  localparam word_t CTX_VPN    = 32'h007F_FFF0;
  localparam int    CTX_SHIFT  = 9;
  localparam word_t PAIR_MASK  = 32'h0000_0FF8;
  localparam word_t ASID_KEEP  = word_t'((64'd1 << ASID_W) - 64'd1);
  localparam word_t VPN2_MASK  = ~word_t'((64'd1 << PAIR_SHIFT) - 64'd1);
  localparam word_t WORD_BYTES = 32'd4;

  word_t va_vpn;
  word_t dir_off;
  word_t pair_off;
  word_t dir_addr;
  word_t pair_addr;

  always_comb begin
    va_vpn    = {va_pair, {PAIR_SHIFT{1'b0}}};
    walk_ctx  = (saved_ctx & ~CTX_FIELD) | ((va_vpn >> CTX_SHIFT) & CTX_VPN);
    walk_ehi  = (saved_ehi & ASID_KEEP) | (va_vpn & VPN2_MASK);
    dir_off   = (va_vpn >> DIR_SHIFT) << 2;
    pair_off  = (walk_ctx >> 1) & PAIR_MASK;
    dir_addr  = (dir_ptr - KSEG_BASE) + dir_off;
    pair_addr = (pt_ptr - KSEG_BASE) + pair_off;
    unique case (phase)
      PH_DIR:  rd_addr = dir_addr;
      PH_EVEN: rd_addr = pair_addr;
      default: rd_addr = pair_addr + WORD_BYTES;
    endcase
  end

endmodule

// File: rtl/ptw_outcome.sv
// Converts the two fetched entries to EntryLo form and grades the access.
module ptw_outcome
  import ptw_pkg::*;
#(
  parameter int PTE_SHIFT  = 6,
  parameter int PAGE_SHIFT = 12,
  parameter int VALID_BIT  = 1,
  parameter int DIRTY_BIT  = 2
) (
  input  logic [31-PTE_SHIFT:0]  ent_even,
  input  logic [31-PTE_SHIFT:0]  ent_odd,
  input  logic [PAGE_SHIFT:0]    va_low,
  input  logic                   is_write,
  output word_t                  lo0,
  output word_t                  lo1,
  output res_code_e              code,
  output word_t                  paddr
);
  localparam int LO_W    = 32 - PTE_SHIFT;
  localparam int FRAME_W = 32 - PAGE_SHIFT;

  logic [FRAME_W-1:0] sel_frame;
  logic               sel_valid;
  logic               sel_dirty;
  logic               use_odd;

  always_comb begin
    lo0      = {{PTE_SHIFT{1'b0}}, ent_even};
    lo1      = {{PTE_SHIFT{1'b0}}, ent_odd};
    use_odd  = va_low[PAGE_SHIFT];
    if (use_odd) begin
      sel_frame = ent_odd[LO_W-1:LO_W-FRAME_W];
      sel_valid = ent_odd[VALID_BIT];
      sel_dirty = ent_odd[DIRTY_BIT];
    end else begin
      sel_frame = ent_even[LO_W-1:LO_W-FRAME_W];
      sel_valid = ent_even[VALID_BIT];
      sel_dirty = ent_even[DIRTY_BIT];
    end
    if (!sel_valid) begin
      code  = RES_INVALID;
      paddr = '0;
    end else if (is_write && !sel_dirty) begin
      code  = RES_DIRTY;
      paddr = '0;
    end else begin
      code  = RES_MATCH;
      paddr = {sel_frame, va_low[PAGE_SHIFT-1:0]};
    end
  end

endmodule

// File: rtl/ptw_refill.sv
module ptw_refill
  import ptw_pkg::*;
#(
  parameter int    IDX_W      = 4,
  parameter int    ASID_W     = 8,
  parameter word_t KSEG_BASE  = 32'h8000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [31:0]      miss_vaddr,
  input  logic             miss_write,
  input  logic [31:0]      dir_base,
  input  logic [31:0]      sw_badva,
  input  logic [31:0]      sw_context,
  input  logic [31:0]      sw_entryhi,
  output logic [31:0]      vis_badva,
  output logic [31:0]      vis_context,
  output logic [31:0]      vis_entryhi,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  input  logic [IDX_W-1:0] rand_idx,
  output logic             tlb_we,
  output logic [IDX_W-1:0] tlb_idx,
  output logic [31:0]      tlb_entryhi,
  output logic [31:0]      tlb_lo0,
  output logic [31:0]      tlb_lo1,
  output logic             res_valid,
  output logic [1:0]       res_code,
  output logic [31:0]      res_paddr
);
  localparam int PAGE_SHIFT = 12;
  localparam int PTE_SHIFT  = 6;
  localparam int LO_W       = 32 - PTE_SHIFT;

  walk_state_e      state_q;
  walk_phase_e      phase_q;
  word_t            va_q;
  logic             wr_q;
  word_t            dir_q;
  word_t            sv_bad_q;
  word_t            sv_ctx_q;
  word_t            sv_ehi_q;
  word_t            pt_q;
  logic [LO_W-1:0]  even_q;
  logic [LO_W-1:0]  odd_q;
  res_code_e        code_q;
  word_t            paddr_q;

  word_t            walk_ctx;
  word_t            walk_ehi;
  word_t            rd_addr;
  word_t            lo0_w;
  word_t            lo1_w;
  res_code_e        out_code;
  word_t            out_paddr;
  logic             take_miss;

  ptw_addr_calc #(
    .KSEG_BASE (KSEG_BASE),
    .ASID_W    (ASID_W),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_addr (
    .phase    (phase_q),
    .va_pair  (va_q[31:PAGE_SHIFT+1]),
    .dir_ptr  (dir_q),
    .pt_ptr   (pt_q),
    .saved_ctx(sv_ctx_q),
    .saved_ehi(sv_ehi_q),
    .walk_ctx (walk_ctx),
    .walk_ehi (walk_ehi),
    .rd_addr  (rd_addr)
  );

  ptw_outcome #(
    .PTE_SHIFT (PTE_SHIFT),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_grade (
    .ent_even(even_q),
    .ent_odd (odd_q),
    .va_low  (va_q[PAGE_SHIFT:0]),
    .is_write(wr_q),
    .lo0     (lo0_w),
    .lo1     (lo1_w),
    .code    (out_code),
    .paddr   (out_paddr)
  );

  assign miss_ready = (state_q == ST_IDLE);
  assign take_miss  = miss_valid && miss_ready;

  // Walk sequencer: directory read, even entry, odd entry, TLB write, result.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_DIR;
      va_q     <= '0;
      wr_q     <= 1'b0;
      dir_q    <= '0;
      sv_bad_q <= '0;
      sv_ctx_q <= '0;
      sv_ehi_q <= '0;
      pt_q     <= '0;
      even_q   <= '0;
      odd_q    <= '0;
      code_q   <= RES_NOMATCH;
      paddr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_miss) begin
            va_q     <= miss_vaddr;
            wr_q     <= miss_write;
            dir_q    <= dir_base;
            sv_bad_q <= sw_badva;
            sv_ctx_q <= sw_context;
            sv_ehi_q <= sw_entryhi;
            phase_q  <= PH_DIR;
            if (dir_base == '0) begin
              code_q  <= RES_NOMATCH;
              paddr_q <= '0;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            unique case (phase_q)
              PH_DIR: begin
                pt_q    <= mem_rsp_data;
                phase_q <= PH_EVEN;
                state_q <= ST_REQ;
              end
              PH_EVEN: begin
                even_q  <= mem_rsp_data[31:PTE_SHIFT];
                phase_q <= PH_ODD;
                state_q <= ST_REQ;
              end
              default: begin
                odd_q   <= mem_rsp_data[31:PTE_SHIFT];
                state_q <= ST_WRITE;
              end
            endcase
          end
        end
        ST_WRITE: begin
          code_q  <= out_code;
          paddr_q <= out_paddr;
          state_q <= ST_DONE;
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = rd_addr;

  assign tlb_we      = (state_q == ST_WRITE);
  assign tlb_idx     = rand_idx;
  assign tlb_entryhi = walk_ehi;
  assign tlb_lo0     = lo0_w;
  assign tlb_lo1     = lo1_w;

  assign res_valid = (state_q == ST_DONE);
  assign res_code  = code_q;
  assign res_paddr = paddr_q;

  // Register views: live when idle, kernel walk values while walking,
  // captured values once the result is issued.
  always_comb begin
    unique case (state_q)
      ST_IDLE: begin
        vis_badva   = sw_badva;
        vis_context = sw_context;
        vis_entryhi = sw_entryhi;
      end
      ST_DONE: begin
        vis_badva   = sv_bad_q;
        vis_context = sv_ctx_q;
        vis_entryhi = sv_ehi_q;
      end
      default: begin
        vis_badva   = va_q;
        vis_context = walk_ctx;
        vis_entryhi = walk_ehi;
      end
    endcase
  end

  assert_result_pulse_R12: assert property (
    @(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid)
    else $error("result pulse longer than one cycle");

  assert_no_accept_on_result_R1: assert property (
    @(posedge clk) disable iff (!rst_n) res_valid |-> !miss_ready)
    else $error("miss accepted during result cycle");

  assert_req_hold_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
    else $error("memory request dropped or changed under back-pressure");

  assert_write_then_result_R5: assert property (
    @(posedge clk) disable iff (!rst_n) tlb_we |=> (res_valid && !tlb_we))
    else $error("TLB write not followed by result");

  assert_zero_dir_abort_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (take_miss && dir_base == '0) |=> (res_valid && res_code == RES_NOMATCH && !mem_req_valid))
    else $error("zero directory did not abort");

  assert_restore_in_result_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (tlb_we && $stable(sv_bad_q)) |=> (vis_badva == $past(sv_bad_q)))
    else $error("fault address not restored");

endmodule

// File: tb/ptw_refill_test.sv
module ptw_refill_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic        miss_write = 1'b0;
  logic [31:0] dir_base = '0;
  logic [31:0] sw_badva = 32'h1111_0000;
  logic [31:0] sw_context = 32'hA280_0000;
  logic [31:0] sw_entryhi = 32'h0000_0042;
  logic [31:0] vis_badva, vis_context, vis_entryhi;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [3:0]  rand_idx = '0;
  logic        tlb_we;
  logic [3:0]  tlb_idx;
  logic [31:0] tlb_entryhi, tlb_lo0, tlb_lo1;
  logic        res_valid;
  logic [1:0]  res_code;
  logic [31:0] res_paddr;

  always #2.5 clk = ~clk;

  ptw_refill #(.IDX_W(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_vaddr(miss_vaddr), .miss_write(miss_write),
    .dir_base(dir_base),
    .sw_badva(sw_badva), .sw_context(sw_context), .sw_entryhi(sw_entryhi),
    .vis_badva(vis_badva), .vis_context(vis_context), .vis_entryhi(vis_entryhi),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rand_idx(rand_idx),
    .tlb_we(tlb_we), .tlb_idx(tlb_idx), .tlb_entryhi(tlb_entryhi),
    .tlb_lo0(tlb_lo0), .tlb_lo1(tlb_lo1),
    .res_valid(res_valid), .res_code(res_code), .res_paddr(res_paddr)
  );

  typedef struct {
    logic [31:0] addr, bad, ctx, ehi;
    bit          is_dir;
  } rd_t;
  typedef struct {
    logic [1:0]  code;
    logic [31:0] paddr, sbad, sctx, sehi;
    bit          nomatch;
  } res_t;
  typedef struct {
    logic [31:0] ehi, lo0, lo1;
  } tlb_t;

  rd_t  rdq[$];
  res_t resq[$];
  tlb_t tlbq[$];
  logic [31:0] mem [logic [31:0]];

  int checks = 0;
  int errors = 0;
  bit stall_mode = 1'b0;
  int lat = 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkpte(input logic [19:0] pfn, input bit v, input bit d);
    return {pfn, 3'b000, d, v, 7'b0} | 32'h0000_002A;
  endfunction

  function automatic logic [31:0] wctx_of(input logic [31:0] va, input logic [31:0] sc);
    return (sc & ~32'h007F_FFFF) | ((va >> 9) & 32'h007F_FFF0);
  endfunction

  // Place a directory word and an entry pair so that va reaches them.
  task automatic set_pair(input logic [31:0] dir, input logic [31:0] va,
                          input logic [31:0] pt, input logic [31:0] pe,
                          input logic [31:0] po);
    logic [31:0] a0, a1;
    a0 = dir - 32'h8000_0000 + {20'b0, va[31:22], 2'b00};
    mem[a0] = pt;
    a1 = pt - 32'h8000_0000 + ((wctx_of(va, 32'h0) >> 1) & 32'h0000_0FF8);
    mem[a1] = pe;
    mem[a1 + 32'd4] = po;
  endtask

  // Driver: computes the expected reads, TLB write and result, then offers the miss.
  task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] dir,
                      input logic [31:0] sb, input logic [31:0] sc,
                      input logic [31:0] se, input bit hold);
    logic [31:0] wctx, wehi, a0, pt, a1, lo0, lo1, sel;
    res_t r;
    tlb_t t;
    rd_t  d;
    wctx = wctx_of(va, sc);
    wehi = (se & 32'h0000_00FF) | (va & ~32'h0000_1FFF);
    r.sbad = sb; r.sctx = sc; r.sehi = se; r.nomatch = 1'b0;
    if (dir == 32'h0) begin
      r.code = 2'd3; r.paddr = 32'h0; r.nomatch = 1'b1;
    end else begin
      a0  = dir - 32'h8000_0000 + {20'b0, va[31:22], 2'b00};
      pt  = rdm(a0);
      a1  = pt - 32'h8000_0000 + ((wctx >> 1) & 32'h0000_0FF8);
      lo0 = rdm(a1) >> 6;
      lo1 = rdm(a1 + 32'd4) >> 6;
      sel = va[12] ? lo1 : lo0;  // R6: bit 12 picks the odd entry
      if (!sel[1]) begin
        r.code = 2'd1; r.paddr = 32'h0;
      end else if (wr && !sel[2]) begin
        r.code = 2'd2; r.paddr = 32'h0;
      end else begin
        r.code = 2'd0; r.paddr = ((sel >> 6) << 12) | (va & 32'h0000_0FFF);
      end
      d.bad = va; d.ctx = wctx; d.ehi = wehi;
      d.addr = a0;           d.is_dir = 1'b1; rdq.push_back(d);
      d.addr = a1;           d.is_dir = 1'b0; rdq.push_back(d);
      d.addr = a1 + 32'd4;   d.is_dir = 1'b0; rdq.push_back(d);
      t.ehi = wehi; t.lo0 = lo0; t.lo1 = lo1;
      tlbq.push_back(t);
    end
    resq.push_back(r);
    @(negedge clk);
    miss_vaddr = va; miss_write = wr; dir_base = dir;
    sw_badva = sb; sw_context = sc; sw_entryhi = se;
    miss_valid = 1'b1;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    if (!hold) miss_valid = 1'b0;
  endtask

  // Replacement index moves away from both clock edges.
  always @(posedge clk) begin
    #1 rand_idx = rand_idx + 4'd7;
  end

  // Memory responder with back-pressure and variable latency.
  int          cyc = 0;
  int          pend = 0;
  logic [31:0] lat_addr = '0;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rdm(lat_addr);
      end
    end
    if (rst_n && prev_stall) begin
      chk("R11", "request held", {31'b0, mem_req_valid}, 32'd1);
      chk("R11", "address held", mem_req_addr, prev_addr);
    end
    mem_req_ready = stall_mode ? ((cyc % 4) == 3) : 1'b1;
    prev_stall = rst_n && mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (rdq.size() == 0) begin
        chk("R9", "unexpected memory read", mem_req_addr, 32'hFFFF_FFFF);
      end else begin
        rd_t e;
        e = rdq.pop_front();
        if (e.is_dir) chk("R2", "directory address", mem_req_addr, e.addr);
        else          chk("R4", "entry address", mem_req_addr, e.addr);
        chk("R3", "walk fault address", vis_badva, e.bad);
        chk("R3", "walk context", vis_context, e.ctx);
        chk("R3", "walk entry-high", vis_entryhi, e.ehi);
      end
      lat_addr = mem_req_addr;
      pend = lat;
    end
  end

  // Monitor: pops expected TLB writes and results as the design issues them.
  bit prev_res = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tlb_we) begin
        if (tlbq.size() == 0) begin
          chk("R9", "unexpected TLB write", 32'd1, 32'd0);
        end else begin
          tlb_t t;
          t = tlbq.pop_front();
          chk("R5", "tlb_idx", {28'b0, tlb_idx}, {28'b0, rand_idx});
          chk("R5", "tlb_entryhi", tlb_entryhi, t.ehi);
          chk("R5", "tlb_lo0", tlb_lo0, t.lo0);
          chk("R5", "tlb_lo1", tlb_lo1, t.lo1);
        end
      end
      if (res_valid) begin
        chk("R12", "result pulse width", {31'b0, prev_res}, 32'd0);
        chk("R1", "miss_ready in result cycle", {31'b0, miss_ready}, 32'd0);
        if (resq.size() == 0) begin
          chk("R12", "unexpected result", 32'd1, 32'd0);
        end else begin
          res_t r;
          r = resq.pop_front();
          if (r.nomatch) chk("R9", "no-match code", {30'b0, res_code}, {30'b0, r.code});
          else           chk("R7", "result code", {30'b0, res_code}, {30'b0, r.code});
          chk("R6/R8", "physical address", res_paddr, r.paddr);
          chk("R10", "restored fault address", vis_badva, r.sbad);
          chk("R10", "restored context", vis_context, r.sctx);
          chk("R10", "restored entry-high", vis_entryhi, r.sehi);
        end
      end
      prev_res = res_valid;
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12: results pending actual %0d expected 0", resq.size());
    summary();
    $finish;
  end

  localparam logic [31:0] DIR = 32'h8010_0000;

  initial begin
    set_pair(DIR, 32'h0040_2345, 32'h8020_0000,
             mkpte(20'h12345, 1'b1, 1'b0), mkpte(20'h0ABCD, 1'b1, 1'b1));
    set_pair(DIR, 32'h0123_5000, 32'h8030_0000,
             mkpte(20'h55555, 1'b1, 1'b1), mkpte(20'h66666, 1'b0, 1'b1));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state and idle pass-through
    chk("R1", "miss_ready after reset", {31'b0, miss_ready}, 32'd1);
    chk("R12", "res_valid after reset", {31'b0, res_valid}, 32'd0);
    chk("R5", "tlb_we after reset", {31'b0, tlb_we}, 32'd0);
    chk("R11", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'd0);
    chk("R10", "idle fault address view", vis_badva, sw_badva);
    chk("R10", "idle context view", vis_context, sw_context);

    // Even entry, read: match
    walk(32'h0040_2345, 1'b0, DIR, 32'h0BAD_0001, 32'hA280_0000, 32'h0000_0011, 1'b0);
    // Odd entry, write, dirty set: match
    walk(32'h0040_3ABC, 1'b1, DIR, 32'h0BAD_0002, 32'hA300_0000, 32'h0000_0022, 1'b0);
    // Even entry, write, dirty clear: dirty fault
    walk(32'h0040_2345, 1'b1, DIR, 32'h0BAD_0003, 32'hFF80_0000, 32'hFFFF_E033, 1'b0);
    // Odd entry with valid clear: invalid
    walk(32'h0123_5000, 1'b0, DIR, 32'h0BAD_0004, 32'h0000_0000, 32'h0000_0044, 1'b0);
    // Zero directory: no match, no reads, no write
    walk(32'h0040_2345, 1'b0, 32'h0, 32'h0BAD_0005, 32'h1234_5678, 32'h0000_0055, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10", "idle view follows input", vis_badva, sw_badva);

    // Back-to-back with the next miss held while busy (R1 overlap)
    walk(32'h0040_3010, 1'b0, DIR, 32'h0BAD_0006, 32'h0080_0000, 32'h0000_0066, 1'b1);
    walk(32'h0123_4FFF, 1'b0, DIR, 32'h0BAD_0007, 32'h0100_0000, 32'h0000_0077, 1'b1);
    walk(32'h3FC0_0000, 1'b0, DIR, 32'h0BAD_0008, 32'h0200_0000, 32'h0000_0088, 1'b0);

    // Memory back-pressure and longer latency
    stall_mode = 1'b1;
    lat = 3;
    walk(32'h0040_3FFF, 1'b1, DIR, 32'h0BAD_0009, 32'h0400_0000, 32'h0000_0099, 1'b1);
    walk(32'h0040_2000, 1'b0, DIR, 32'h0BAD_000A, 32'h0800_0000, 32'h0000_00AA, 1'b0);

    while (resq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R5", "TLB writes left over", tlbq.size(), 32'd0);
    chk("R4", "reads left over", rdq.size(), 32'd0);
    summary();
    $finish;
  end

endmodule